// File: doc/BRIEF.md
# Converter Serial Result Output Shifter

This block is the device side of a read-only serial port on a sampling converter. The conversion engine hands it a result word and three flags when a conversion finishes: channel, sign and out-of-range. The host selects the device with an active-low select line and supplies its own serial clock. The block answers with a 24-bit frame on a single data line. It also provides an enable for the line's tri-state driver, so the line floats while the device is not selected.

The first bit of every frame is not latched data. It is a live readiness flag that tracks an internal "conversion running" state, so a host can hold select low and wait for the line to drop before it starts clocking. When the last clock edge of a complete frame arrives, the frame ends and the block pulses a start request to the conversion engine. The line then returns high to show the new conversion, and that high level is the first bit of the next frame. Both the serial clock and the select line are asynchronous to the system clock, so they are synchronized and edge-detected inside the block. Results are staged so that a late completion can never alter a frame the host is still reading.

Top module: `adc_frame_tx`

## Requirements
- R1: A complete frame carries, from first to last: frame bit 23 = readiness flag (1 = conversion running, 0 = result ready), bit 22 = channel, bit 21 = sign, bit 20 = out-of-range flag, then bits 19..0 = the result word, most significant bit first.
- R2: While select is low and no clock edge has yet arrived, the data line shows the readiness flag live: a completion pulse makes it fall within four system clock cycles, with no select toggle needed.
- R3: After reset the block treats a conversion as running. The output enable and the start request are low, and the first bit read shows 1.
- R4: While select is high, the output enable is low, the data line is driven 0, and serial clock activity does not move the bit position. The next frame therefore still begins at bit 23.
- R5: Bits advance only on falling serial clock edges: bit 22 appears after the first falling edge and bit 0 after the 23rd.
- R6: On the 24th falling edge of a frame, the start request pulses high for exactly one system clock cycle. The data line then shows 1 as bit 23 of the next frame.
- R7: If select rises before the 24th falling edge, the bit position returns to bit 23, no start request is issued, and the readiness flag keeps its value. A fresh read returns the same frame from its start.
- R8: A completion that arrives while a frame is partly shifted does not change that frame. Its result is presented once the bit position is back at bit 23.
- R9: A completion pulse in the same system clock cycle as the 24th falling edge is discarded. The readiness flag stays 1 for the new conversion.
- R10: With the single-channel option selected, frame bit 22 is always 0, whatever the channel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle pulse from the conversion engine: result and flags valid |
| res_data | input | RES_W | Conversion result word |
| res_chan | input | 1 | Channel of the finished conversion (0 or 1) |
| res_sign | input | 1 | Sign of the input: 1 positive, 0 negative |
| res_ovr | input | 1 | Input outside the zero-to-reference span |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| csn_in | input | 1 | Active-low select from the host, asynchronous |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Enable for the data line's tri-state driver |
| conv_start | output | 1 | One-cycle request to start the next conversion |

## Verification
Two events can land in the same system clock cycle: the engine's completion pulse and the detected 24th falling edge that ends a frame and restarts conversion. The bench provokes this by placing the last clock fall at a known edge. It then counts the two synchronizer stages and raises the completion pulse so that it is sampled in the cycle where the edge is detected. The outcome is judged at the pins. The data line must read 1 immediately after the edge and still read 1 twenty cycles later. Exactly one start request must be seen. The next completion must then produce an ordinary, correct frame.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

   // status flags that travel with a result word
   localparam int unsigned FLAG_BITS = 3;

   typedef struct packed {
      logic chan;
      logic sign;
      logic ovr;
   } conv_flags_t;

endpackage

// File: rtl/afx_sync.sv
module afx_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("afx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/afx_bit_seq.sv
module afx_bit_seq #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned CNT_W   = $clog2(FRAME_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             cs_act,
   output logic [CNT_W-1:0] cnt,
   output logic             restart,
   output logic             start_pulse
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic sclk_d;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign fall    = sclk_d & ~sclk_s;
   assign restart = fall & cs_act & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!cs_act) begin
         cnt <= '0;
      end else if (fall) begin
         if (cnt == LAST) cnt <= '0;
         else             cnt <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_pulse <= 1'b0;
      else        start_pulse <= restart;
   end

endmodule

// File: rtl/afx_result_hold.sv
module afx_result_hold
   import adc_frame_pkg::*;
#(
   parameter int unsigned RES_W     = 20,
   parameter bit          DUAL_CHAN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [RES_W-1:0] data_in,
   input  conv_flags_t      flags_in,
   input  logic             restart,
   input  logic             idle,
   output logic [RES_W-1:0] hold_data,
   output conv_flags_t      hold_flags,
   output logic             run,
   output logic             shadow_v
);

   conv_flags_t      flags_m;
   logic [RES_W-1:0] shadow_data;
   conv_flags_t      shadow_flags;
   logic             take;
   logic             load;

   if (DUAL_CHAN) begin : g_dual
      assign flags_m = flags_in;
   end else begin : g_single
      assign flags_m = '{chan: 1'b0, sign: flags_in.sign, ovr: flags_in.ovr};
   end

   // a completion in the restart cycle is dropped
   assign take = done & ~restart;
   // hand over only when no frame is part-way out
   assign load = shadow_v & idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_data  <= '0;
         shadow_flags <= '0;
         shadow_v     <= 1'b0;
      end else if (take) begin
         shadow_data  <= data_in;
         shadow_flags <= flags_m;
         shadow_v     <= 1'b1;
      end else if (load) begin
         shadow_v     <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data  <= '0;
         hold_flags <= '0;
      end else if (load) begin
         hold_data  <= shadow_data;
         hold_flags <= shadow_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run <= 1'b1;
      else if (load)    run <= 1'b0;
      else if (restart) run <= 1'b1;
   end

endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
   import adc_frame_pkg::*;
#(
   parameter int unsigned RES_W       = 20,
   parameter bit          DUAL_CHAN   = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done,
   input  logic [RES_W-1:0] res_data,
   input  logic             res_chan,
   input  logic             res_sign,
   input  logic             res_ovr,
   input  logic             sclk_in,
   input  logic             csn_in,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             conv_start
);

   localparam int unsigned FRAME_W = RES_W + FLAG_BITS + 1;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);

   if (RES_W < 1) begin : g_bad_width
      $error("adc_frame_tx: RES_W must be at least 1");
   end

   logic [1:0]         pins_s;
   logic               sclk_s;
   logic               cs_act;
   logic [CNT_W-1:0]   cnt;
   logic               restart;
   logic [RES_W-1:0]   hold_data;
   conv_flags_t        hold_flags;
   conv_flags_t        flags_in;
   logic               run;
   logic               shadow_v;
   logic [FRAME_W-1:0] frame_w;
   logic [CNT_W-1:0]   sel;

   afx_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b10)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({csn_in, sclk_in}),
      .dout  (pins_s)
   );

   assign sclk_s = pins_s[0];
   assign cs_act = ~pins_s[1];

   afx_bit_seq #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (sclk_s),
      .cs_act      (cs_act),
      .cnt         (cnt),
      .restart     (restart),
      .start_pulse (conv_start)
   );

   assign flags_in = '{chan: res_chan, sign: res_sign, ovr: res_ovr};

   afx_result_hold #(
      .RES_W     (RES_W),
      .DUAL_CHAN (DUAL_CHAN)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (conv_done),
      .data_in    (res_data),
      .flags_in   (flags_in),
      .restart    (restart),
      .idle       (cnt == '0),
      .hold_data  (hold_data),
      .hold_flags (hold_flags),
      .run        (run),
      .shadow_v   (shadow_v)
   );

   // readiness flag first, then channel, sign, range, result
   assign frame_w = {run, hold_flags.chan, hold_flags.sign, hold_flags.ovr, hold_data};
   assign sel     = CNT_W'(FRAME_W - 1) - cnt;
   assign sdo     = cs_act & frame_w[sel];
   assign sdo_oe  = cs_act;

endmodule

// File: rtl/adc_frame_tx_checker.sv
module afx_frame_checker #(
   parameter int unsigned RES_W = 20,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_act,
   input logic [CNT_W-1:0] cnt,
   input logic             conv_start,
   input logic             conv_done,
   input logic             restart,
   input logic             run,
   input logic             shadow_v,
   input logic [RES_W-1:0] hold_data
);

   // R6: start request lasts a single cycle
   assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R6: during the start request the readiness flag reads busy
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> run);

   // R7: deselect brings the bit position back to the first bit
   assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (cnt == '0));

   // R8: the presented result is frozen while a frame is part-way out
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(hold_data));

   // R2: a staged result at the first bit position clears the flag next cycle
   assert_eoc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_v && (cnt == '0)) |=> !run);

   // R9: coincident completion is dropped and the flag stays busy
   assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && conv_done && !shadow_v) |=> (run && !shadow_v));

endmodule

bind adc_frame_tx afx_frame_checker #(
   .RES_W (RES_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_act     (cs_act),
   .cnt        (cnt),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .restart    (restart),
   .run        (run),
   .shadow_v   (shadow_v),
   .hold_data  (hold_data)
);

// File: tb/adc_frame_tx_tb.sv
`timescale 1ns/1ps
module adc_frame_tx_tb;

   localparam int RW = 20;
   localparam int FW = 24;
   localparam int SETTLE = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_done = 1'b0;
   logic [RW-1:0] res_data = '0;
   logic          res_chan = 1'b0;
   logic          res_sign = 1'b0;
   logic          res_ovr = 1'b0;
   logic          sclk = 1'b0;
   logic          csn = 1'b1;
   logic          sdo, sdo_oe, conv_start;
   logic          sdo_s, oe_s, start_s;

   always #4 clk = ~clk;

   adc_frame_tx #(.RES_W(RW), .DUAL_CHAN(1'b1), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .res_data(res_data),
      .res_chan(res_chan), .res_sign(res_sign), .res_ovr(res_ovr),
      .sclk_in(sclk), .csn_in(csn), .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start));

   adc_frame_tx #(.RES_W(RW), .DUAL_CHAN(1'b0), .SYNC_STAGES(2)) u_single (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .res_data(res_data),
      .res_chan(res_chan), .res_sign(res_sign), .res_ovr(res_ovr),
      .sclk_in(sclk), .csn_in(csn), .sdo(sdo_s), .sdo_oe(oe_s), .conv_start(start_s));

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   typedef struct {
      logic [FW-1:0] frame;
      string         tag;
   } exp_t;

   exp_t          exp_q[$];
   logic [FW-1:0] got_frame, got_single;
   event          frame_ev;

   always @(posedge clk) if (rst_n && conv_start) pulses++;

   task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mk(input logic [RW-1:0] d, input logic ch,
                                        input logic sg, input logic ov);
      return {1'b0, ch, sg, ov, d};
   endfunction

   task automatic expect_frame(input logic [FW-1:0] f, input string tag);
      exp_t e;
      e.frame = f;
      e.tag   = tag;
      exp_q.push_back(e);
   endtask

   // scoreboard monitor: compares each captured frame with the next expected one
   initial begin
      forever begin
         @(frame_ev);
         if (exp_q.size() == 0) begin
            check("R1 (no expected frame)", got_frame, 'x);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, got_frame, e.frame);
            check("R10 single-channel", got_single, e.frame & ~(24'h1 << 22));
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_done(input logic [RW-1:0] d, input logic ch, input logic sg, input logic ov);
      @(negedge clk);
      res_data = d; res_chan = ch; res_sign = sg; res_ovr = ov;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic finish_conv(input logic [RW-1:0] d, input logic ch, input logic sg, input logic ov);
      pulse_done(d, ch, sg, ov);
      wait_n(4);
   endtask

   task automatic cs_low();
      @(negedge clk); csn = 1'b0; wait_n(SETTLE);
   endtask

   task automatic cs_high();
      @(negedge clk); csn = 1'b1; wait_n(SETTLE);
   endtask

   task automatic fall_once();
      @(negedge clk); sclk = 1'b1; wait_n(SETTLE);
      sclk = 1'b0; wait_n(SETTLE);
   endtask

   task automatic read_body(inout logic [FW-1:0] g, inout logic [FW-1:0] gs,
                            input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         fall_once();
         g[i]  = sdo;
         gs[i] = sdo_s;
      end
   endtask

   task automatic post(input logic [FW-1:0] g, input logic [FW-1:0] gs);
      got_frame  = g;
      got_single = gs;
      -> frame_ev;
      #1;
   endtask

   // full frame read, then the 24th falling edge
   task automatic read_frame(input bit already_low);
      logic [FW-1:0] g, gs;
      int p0;
      g = '0; gs = '0;
      if (!already_low) cs_low();
      g[FW-1]  = sdo;
      gs[FW-1] = sdo_s;
      read_body(g, gs, FW-2, 0);
      post(g, gs);
      p0 = pulses;
      fall_once();
      check("R6 line high after last edge", {23'd0, sdo}, 24'd1);
      check("R6 one start request", pulses, p0 + 1);
      cs_high();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [FW-1:0] g, gs;
      int p0;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(SETTLE);

      // R3: reset state
      check("R3 enable low", {23'd0, sdo_oe}, 24'd0);
      check("R3 no start request", pulses, 0);
      cs_low();
      check("R3 first bit busy", {23'd0, sdo}, 24'd1);
      check("R4 enable while selected", {23'd0, sdo_oe}, 24'd1);
      cs_high();

      // R1 R5 R6: ordinary frame
      finish_conv(20'hA5C3F, 1'b1, 1'b1, 1'b0);
      expect_frame(mk(20'hA5C3F, 1'b1, 1'b1, 1'b0), "R1 R5 frame A");
      read_frame(1'b0);

      // R2: live readiness flag while select is held low
      cs_low();
      check("R2 busy before completion", {23'd0, sdo}, 24'd1);
      pulse_done(20'h00001, 1'b0, 1'b0, 1'b1);
      wait_n(4);
      check("R2 ready without reselect", {23'd0, sdo}, 24'd0);
      expect_frame(mk(20'h00001, 1'b0, 1'b0, 1'b1), "R2 frame B");
      read_frame(1'b1);

      // R4: clocks ignored while deselected
      finish_conv(20'hFFFFE, 1'b1, 1'b0, 1'b1);
      p0 = pulses;
      for (int k = 0; k < 30; k++) fall_once();
      check("R4 enable low", {23'd0, sdo_oe}, 24'd0);
      check("R4 line driven 0", {23'd0, sdo}, 24'd0);
      check("R4 no start request", pulses, p0);
      expect_frame(mk(20'hFFFFE, 1'b1, 1'b0, 1'b1), "R4 frame C from bit 23");
      read_frame(1'b0);

      // R7: early deselect
      finish_conv(20'h3C96A, 1'b0, 1'b1, 1'b0);
      p0 = pulses;
      g = '0; gs = '0;
      cs_low();
      read_body(g, gs, FW-2, FW-11);
      cs_high();
      check("R7 no start request", pulses, p0);
      check("R7 enable low", {23'd0, sdo_oe}, 24'd0);
      cs_low();
      check("R7 flag still ready", {23'd0, sdo}, 24'd0);
      cs_high();
      expect_frame(mk(20'h3C96A, 1'b0, 1'b1, 1'b0), "R7 frame D reread");
      read_frame(1'b0);

      // R8: completion while a frame is part-way out
      finish_conv(20'h12345, 1'b1, 1'b0, 1'b0);
      expect_frame(mk(20'h12345, 1'b1, 1'b0, 1'b0), "R8 frame E intact");
      g = '0; gs = '0;
      cs_low();
      g[FW-1] = sdo; gs[FW-1] = sdo_s;
      read_body(g, gs, FW-2, FW-6);
      pulse_done(20'hEDCBA, 1'b0, 1'b1, 1'b1);
      read_body(g, gs, FW-7, 0);
      post(g, gs);
      p0 = pulses;
      cs_high();
      check("R8 no start request", pulses, p0);
      expect_frame(mk(20'hEDCBA, 1'b0, 1'b1, 1'b1), "R8 frame F after");
      read_frame(1'b0);

      // R9: completion in the cycle of the 24th falling edge
      finish_conv(20'h0F0F0, 1'b1, 1'b1, 1'b1);
      expect_frame(mk(20'h0F0F0, 1'b1, 1'b1, 1'b1), "R9 frame G");
      g = '0; gs = '0;
      cs_low();
      g[FW-1] = sdo; gs[FW-1] = sdo_s;
      read_body(g, gs, FW-2, 0);
      post(g, gs);
      p0 = pulses;
      @(negedge clk); sclk = 1'b1; wait_n(SETTLE);
      sclk = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      res_data = 20'h55555; res_chan = 1'b0; res_sign = 1'b0; res_ovr = 1'b0;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      wait_n(SETTLE);
      check("R9 flag busy after drop", {23'd0, sdo}, 24'd1);
      wait_n(20);
      check("R9 flag still busy", {23'd0, sdo}, 24'd1);
      check("R9 one start request", pulses, p0 + 1);
      cs_high();
      finish_conv(20'h80000, 1'b1, 1'b0, 1'b0);
      expect_frame(mk(20'h80000, 1'b1, 1'b0, 1'b0), "R9 frame J");
      read_frame(1'b0);

      wait_n(5);
      check("R1 scoreboard drained", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule